// File: doc/BRIEF.md
# Parking Bus Arbiter with Transaction Watch

This block decides which of several agents on a shared parallel bus may drive the next transaction. Any agent may ask for the bus: the ones that start ordinary reads and writes, and also the responders that have to come back later with a split completion. Each agent has its own request line and its own grant line. Priority is fixed, and the agent with the lowest index always wins. All decisions are taken on the rising clock edge, and the grant output comes from a register.

The arbiter also watches two bus status lines that every agent shares. The cycle line is high while a transaction is in progress. The ready line is high while the active initiator is in its data handshake. The arbiter takes the bus away from its owner only when the bus is idle (both lines low) or when the owner has already begun its own transaction. In the second case the owner keeps the bus through the framing it has started, even after it loses the grant. Every change of owner passes through one cycle in which no grant is asserted. When nobody is asking and the bus is idle, the grant is parked on a default agent, which can then start at once without a request.

All request, grant and bus lines are active high in this block. A set bit means the signal is asserted, so the low-true levels found on a real backplane are converted outside the block.

Top module: `park_bus_arbiter`

## Requirements
- R1: At most one bit of `agent_gnt` is 1 in any cycle.
- R2: A grant never passes straight from one agent to another. A nonzero `agent_gnt` either stays unchanged or goes to all-zero, so every new grant comes out of an all-zero cycle.
- R3: When `agent_gnt` is all-zero and `agent_req` is nonzero at a rising edge, the grant after that edge is the lowest-numbered set bit of `agent_req` (bit 0 has the highest priority).
- R4: When `agent_gnt` is all-zero, no agent requests and the bus is idle (`bus_cycle`=0 and `bus_ready`=0) at a rising edge, the grant goes to agent `PARK_IDX`. A parked agent that does not request keeps the grant for as long as nobody else requests.
- R5: An owner loses its grant to another requester only if the bus is idle, or if `bus_cycle` rose while that owner held the grant. Otherwise the grant is held, even while other agents request.
- R6: An owner other than the park agent that drops its request while the bus is idle loses its grant at the next edge. While the bus is busy it keeps the grant.
- R7: An owner that requests while no other agent requests keeps its grant.
- R8: When `agent_gnt` is all-zero, no agent requests and the bus is busy, the grant stays all-zero, so nothing is parked.
- R9: While `rst_n` is low, `agent_gnt` is all-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every decision is taken on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| agent_req | input | N_REQ | Request from each agent, 1 = wants the bus |
| bus_cycle | input | 1 | Shared transaction framing line, 1 = transaction in progress |
| bus_ready | input | 1 | Shared initiator-ready line, 1 = data handshake active |
| agent_gnt | output | N_REQ | Grant to each agent, one-hot or all-zero |

## Verification
The bound checker checks on every cycle that the grant is one-hot or empty, that it always passes through an empty cycle, that new grants follow priority, that parking happens only when the bus is idle, and that grants are held or withdrawn correctly with respect to the owner's request and the address-phase flag. Only the bench scenarios can show the longer interactions: an owner keeping its grant across a busy bus while a higher-priority agent waits, a handover as soon as the owner has started its own transaction, the grant staying empty while an abandoned transaction finishes, and the reset value. A long pseudo-random sweep compares every cycle against an arithmetic model built from the requirements.

// File: rtl/pba_pkg.sv
package pba_pkg;

   // What the grant register does at the next rising edge
   typedef enum logic [1:0] {
      ACT_HOLD    = 2'd0,
      ACT_RELEASE = 2'd1,
      ACT_GRANT   = 2'd2,
      ACT_PARK    = 2'd3
   } pba_act_e;

endpackage

// File: rtl/pba_lowest_pick.sv
module pba_lowest_pick #(
   parameter int N_REQ = 4
) (
   input  logic [N_REQ-1:0] vec,
   output logic [N_REQ-1:0] onehot,
   output logic             any
);
   // below[i] is set when some bit with index lower than i is set
   logic [N_REQ:0] below;

   assign below[0] = 1'b0;

   for (genvar i = 0; i < N_REQ; i++) begin : g_bit
      assign below[i+1] = below[i] | vec[i];
      assign onehot[i]  = vec[i] & ~below[i];
   end

   assign any = below[N_REQ];
endmodule

// File: rtl/pba_bus_watch.sv
module pba_bus_watch (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_cycle,
   input  logic bus_ready,
   input  logic owned,
   input  logic owner_change,
   output logic bus_idle,
   output logic addr_seen
);
   logic cycle_q;
   logic cycle_rise;

   assign bus_idle   = ~bus_cycle & ~bus_ready;
   assign cycle_rise = bus_cycle & ~cycle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cycle_q   <= 1'b0;
         addr_seen <= 1'b0;
      end else begin
         cycle_q <= bus_cycle;
         if (owner_change)
            addr_seen <= 1'b0;
         else if (owned && cycle_rise)
            addr_seen <= 1'b1;
      end
   end
endmodule

// File: rtl/pba_grant_ctl.sv
module pba_grant_ctl
   import pba_pkg::*;
#(
   parameter int N_REQ    = 4,
   parameter int PARK_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req,
   input  logic [N_REQ-1:0] pick,
   input  logic             pick_any,
   input  logic             bus_idle,
   input  logic             addr_seen,
   output logic [N_REQ-1:0] gnt,
   output logic             changing
);
   localparam logic [N_REQ-1:0] PARK_VEC = {{(N_REQ-1){1'b0}}, 1'b1} << PARK_IDX;

   pba_act_e         act;
   logic [N_REQ-1:0] gnt_d;
   logic             owned;
   logic             owner_req;
   logic             rivals;
   logic             parked;

   assign owned     = |gnt;
   assign owner_req = |(req & gnt);
   assign rivals    = |(req & ~gnt);
   assign parked    = (gnt == PARK_VEC);

   always_comb begin
      act = ACT_HOLD;
      if (owned) begin
         if (rivals && (bus_idle || addr_seen))
            act = ACT_RELEASE;
         else if (!owner_req && bus_idle && !parked)
            act = ACT_RELEASE;
      end else begin
         if (pick_any)
            act = ACT_GRANT;
         else if (bus_idle)
            act = ACT_PARK;
      end
   end

   always_comb begin
      unique case (act)
         ACT_RELEASE: gnt_d = '0;
         ACT_GRANT:   gnt_d = pick;
         ACT_PARK:    gnt_d = PARK_VEC;
         default:     gnt_d = gnt;
      endcase
   end

   assign changing = (gnt_d != gnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gnt <= '0;
      else        gnt <= gnt_d;
   end
endmodule

// File: rtl/park_bus_arbiter.sv
module park_bus_arbiter #(
   parameter int N_REQ    = 4,
   parameter int PARK_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] agent_req,
   input  logic             bus_cycle,
   input  logic             bus_ready,
   output logic [N_REQ-1:0] agent_gnt
);
   initial begin : p_param_chk
      assert (N_REQ >= 2) else $fatal(1, "N_REQ must be at least 2");
      assert (PARK_IDX >= 0 && PARK_IDX < N_REQ) else $fatal(1, "PARK_IDX out of range");
   end

   logic [N_REQ-1:0] pick_vec;
   logic             pick_any;
   logic             bus_idle;
   logic             own_addr_seen;
   logic             owner_change;

   pba_lowest_pick #(.N_REQ(N_REQ)) u_pick (
      .vec    (agent_req),
      .onehot (pick_vec),
      .any    (pick_any)
   );

   pba_bus_watch u_watch (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_cycle    (bus_cycle),
      .bus_ready    (bus_ready),
      .owned        (|agent_gnt),
      .owner_change (owner_change),
      .bus_idle     (bus_idle),
      .addr_seen    (own_addr_seen)
   );

   pba_grant_ctl #(.N_REQ(N_REQ), .PARK_IDX(PARK_IDX)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (agent_req),
      .pick      (pick_vec),
      .pick_any  (pick_any),
      .bus_idle  (bus_idle),
      .addr_seen (own_addr_seen),
      .gnt       (agent_gnt),
      .changing  (owner_change)
   );
endmodule

// File: rtl/pba_checker.sv
module pba_checker #(
   parameter int N_REQ    = 4,
   parameter int PARK_IDX = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_REQ-1:0] req,
   input logic             bus_cycle,
   input logic             bus_ready,
   input logic [N_REQ-1:0] gnt,
   input logic             addr_seen
);
   localparam logic [N_REQ-1:0] PARK_VEC = {{(N_REQ-1){1'b0}}, 1'b1} << PARK_IDX;

   logic busy;
   assign busy = bus_cycle | bus_ready;

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)); // R1

   AST_EMPTY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0) |=> (gnt == $past(gnt)) || (gnt == '0)); // R2

   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && req != '0) |=> gnt == ($past(req) & (~$past(req) + 1'b1))); // R3

   AST_PARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && req == '0 && !busy) |=> gnt == PARK_VEC); // R4

   AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0 && (req & gnt) != '0 && busy && !addr_seen) |=> gnt == $past(gnt)); // R5

   AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0 && (req & gnt) == '0 && gnt != PARK_VEC && !busy) |=> gnt == '0); // R6

   AST_OWNER_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0 && req == gnt) |=> gnt == $past(gnt)); // R7

   AST_NO_PARK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && req == '0 && busy) |=> gnt == '0); // R8
endmodule

bind park_bus_arbiter pba_checker #(.N_REQ(N_REQ), .PARK_IDX(PARK_IDX)) u_pba_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (agent_req),
   .bus_cycle (bus_cycle),
   .bus_ready (bus_ready),
   .gnt       (agent_gnt),
   .addr_seen (own_addr_seen)
);

// File: tb/tb_park_bus_arbiter.sv
`timescale 1ns/1ps
module tb_park_bus_arbiter;
   localparam int N   = 4;
   localparam int PRK = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic         cyc = 1'b0;
   logic         rdy = 1'b0;
   logic [N-1:0] gnt;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   park_bus_arbiter #(.N_REQ(N), .PARK_IDX(PRK)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .agent_req (req),
      .bus_cycle (cyc),
      .bus_ready (rdy),
      .agent_gnt (gnt)
   );

   // Reference model written from the requirements
   logic [N-1:0] m_gnt;
   logic         m_seen;
   logic         m_cyc_q;

   function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
      for (int i = 0; i < N; i++)
         if (v[i]) return N'(1) << i;
      return '0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_gnt <= '0; m_seen <= 1'b0; m_cyc_q <= 1'b0;
      end else begin
         logic [N-1:0] nx;
         logic idle;
         idle = !cyc && !rdy;
         nx = m_gnt;
         if (m_gnt != '0) begin
            if ((req & ~m_gnt) != '0 && (idle || m_seen)) nx = '0;
            else if ((req & m_gnt) == '0 && idle && m_gnt != (N'(1) << PRK)) nx = '0;
         end else if (req != '0) nx = lowest(req);
         else if (idle) nx = N'(1) << PRK;
         if (nx != m_gnt) m_seen <= 1'b0;
         else if (m_gnt != '0 && cyc && !m_cyc_q) m_seen <= 1'b1;
         m_gnt   <= nx;
         m_cyc_q <= cyc;
      end
   end

   task automatic chk(input string tag, input logic [N-1:0] exp);
      n_chk++;
      if (gnt !== exp) begin
         n_fail++;
         $display("FAIL %s: agent_gnt=%b expected=%b at %0t", tag, gnt, exp, $time);
      end
   endtask

   // drive inputs at the falling edge, look just after the next rising edge
   task automatic tick(input logic [N-1:0] r, input logic c, input logic d);
      @(negedge clk);
      req = r; cyc = c; rdy = d;
      @(posedge clk);
      #2;
   endtask

   initial begin : watchdog
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      chk("R9 grant empty in reset", '0);
      rst_n = 1'b1;

      tick(4'b0000, 0, 0); chk("R4 park after reset", 4'b0100);
      tick(4'b1010, 0, 0); chk("R2 gap before handover", 4'b0000);
      tick(4'b1010, 0, 0); chk("R3 lowest of 1010", 4'b0010);
      tick(4'b0010, 0, 0); chk("R7 sole owner keeps", 4'b0010);
      tick(4'b0010, 1, 0); chk("R7 owner starts cycle", 4'b0010);
      tick(4'b0001, 1, 1); chk("R5 release after own address phase", 4'b0000);
      tick(4'b1001, 1, 1); chk("R3 grant during old transaction", 4'b0001);
      tick(4'b1001, 1, 1); chk("R5 hold while busy", 4'b0001);
      tick(4'b1001, 1, 1); chk("R5 hold while busy", 4'b0001);
      tick(4'b1001, 0, 1); chk("R5 hold while ready high", 4'b0001);
      tick(4'b1001, 0, 0); chk("R5 release on idle", 4'b0000);
      tick(4'b1001, 0, 0); chk("R3 lowest of 1001", 4'b0001);
      tick(4'b1000, 0, 0); chk("R5 release to rival when idle", 4'b0000);
      tick(4'b1000, 0, 0); chk("R3 single requester", 4'b1000);
      tick(4'b1000, 1, 0); chk("R7 owner starts cycle", 4'b1000);
      tick(4'b0000, 1, 1); chk("R6 drop while busy keeps", 4'b1000);
      tick(4'b0001, 1, 1); chk("R5 release after address phase", 4'b0000);
      tick(4'b0000, 1, 1); chk("R8 no park while busy", 4'b0000);
      tick(4'b0000, 1, 0); chk("R8 no park while busy", 4'b0000);
      tick(4'b0000, 0, 0); chk("R4 park on idle", 4'b0100);
      tick(4'b0100, 0, 0); chk("R7 parked agent requests", 4'b0100);
      tick(4'b0000, 0, 0); chk("R4 parked agent stays", 4'b0100);
      tick(4'b0010, 0, 0); chk("R2 leave park", 4'b0000);
      tick(4'b0010, 0, 0); chk("R3 grant agent 1", 4'b0010);
      tick(4'b0000, 0, 0); chk("R6 drop while idle", 4'b0000);
      tick(4'b0000, 0, 0); chk("R4 back to park", 4'b0100);

      // pseudo-random sweep against the model
      lfsr = 16'hACE1;
      for (int k = 0; k < 4000; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         tick(lfsr[3:0] & {N{lfsr[8]}}, lfsr[5] & lfsr[9], lfsr[6] & lfsr[11]);
         chk("R3 sweep vs model", m_gnt);
         n_chk++;
         if (!$onehot0(gnt)) begin
            n_fail++;
            $display("FAIL R1: agent_gnt=%b expected one-hot or zero", gnt);
         end
      end

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule